// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. A requester offers the address, the kind of access (read, write or execute) and a privilege mode index, together with the base address of the top-level page table. The walker first rejects addresses that are not properly sign-extended. It then recognises a direct-mapped kernel superpage, which it resolves without touching memory. Any other address is resolved by reading up to three 8-byte table entries through a simple read port with separate request and response signals.

The controller is a five-state machine:
- **IDLE** accepts a request. It goes to DONE for a rejected or superpage address, and to L1 otherwise.
- **L1** and **L2** each hold a memory read open until its response arrives. They go to DONE on a fault, or to the next level once the entry has been accepted.
- **L3** reads the leaf entry, judges the permissions and goes to DONE.
- **DONE** presents the result for exactly one cycle and returns to IDLE.

Pages are 8 KB (13 offset bits), and 43 virtual address bits are implemented.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `done_valid` and `mem_req_valid` are 0.
- R2: An address whose bits 63 down to 42 are not all equal completes with fault code 1 (access violation) and makes no memory read. Fault codes are: 0 none, 1 access violation, 2 entry not valid, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute.
- R3: A canonical address with bit 63 set and bits 42:41 equal to 2'b10 is a superpage, and it makes no memory read. In mode 0 it yields physical bits 39:0 equal to virtual bits 39:0, physical bit 43 equal to virtual bit 40, all other bits 0, and permissions 3'b111. In any other mode it yields fault 1. Permission bits are bit0 read, bit1 write and bit2 execute.
- R4: The level 1, 2 and 3 indexes are virtual bits 42:33, 32:23 and 22:13. Each entry is read at the current table base plus the index times 8, and the level 1 base is `ptbr`.
- R5: The next table base, and the final frame, is entry bits 63:32 shifted left by 13. A successful physical address is that frame ORed with virtual bits 12:0.
- R6: An entry with bit 0 (valid) clear, at any level, gives fault 2.
- R7: A valid level 1 or level 2 entry with bit 8 (kernel read enable) clear gives fault 1.
- R8: At level 3, read and execute are granted by entry bit 8+mode and write by entry bit 12+mode. If the needed permission is not granted, the fault is 1. The access encoding is 0 read, 1 write, 2 execute; code 3 is treated as read.
- R9: Entry bits 1, 2 and 3 remove read, write and execute respectively from the granted set, and `done_perm` reports the reduced set. If the needed permission is lost, the fault is 5 for execute, 4 for write or 3 for read, judged in that priority order.
- R10: `req_ready` is 1 only in IDLE. While a memory read is open, its address stays stable until `mem_rsp_valid` is seen.
- R11: `done_valid` is high for exactly one cycle per request. On any fault, `done_pa` and `done_perm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_mode | input | 2 | Privilege mode index, 0 is kernel |
| ptbr | input | 64 | Base address of the level 1 table |
| mem_req_valid | output | 1 | Memory read open |
| mem_req_addr | output | 64 | Address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry read from memory |
| done_valid | output | 1 | Result valid, one cycle |
| done_pa | output | 64 | Physical address |
| done_perm | output | 3 | Granted permissions {execute, write, read} |
| done_fault | output | 3 | Fault code, 0 when the translation succeeded |

## Verification
The assertions rely on three things about the surrounding logic:
- A memory response arrives only while a read is open, and only once per read.
- `ptbr` stays constant during a walk.
- A new request is offered only while `req_ready` is high.

The bench memory model keeps to these. It opens a single pending read for each new level, answers after a fixed latency, and drops its response the cycle after the walker consumes it. The stimulus raises `req_valid` for a single cycle only when the walker is idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    // Fixed entry width and entry bit positions the walk decodes
    localparam int PTE_W    = 64;
    localparam int PTE_V    = 0;
    localparam int PTE_FOR  = 1;
    localparam int PTE_FOW  = 2;
    localparam int PTE_FOE  = 3;
    localparam int PTE_KRE  = 8;
    localparam int PTE_KWE  = 12;
    localparam int MODE_W   = 2;
    localparam int PERM_W   = 3;
    localparam int PERM_R   = 0;
    localparam int PERM_W_B = 1;
    localparam int PERM_X   = 2;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } ptw_fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1,
        ST_L2,
        ST_L3,
        ST_DONE
    } ptw_state_e;
endpackage

// File: rtl/ptw_front.sv
module ptw_front
    import ptw_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VIRT_BITS = 43,
    parameter int PA_W      = 64
) (
    input  logic [VA_W-1:0]   va,
    input  logic [MODE_W-1:0] mode,
    output logic              canon,
    output logic              sp_hit,
    output logic              acv,
    output logic [PA_W-1:0]   sp_pa
);
    // Superpage selector sits just below the top implemented bit
    localparam int SP_SEL_LO = VIRT_BITS - 2;
    localparam int SP_LOW_W  = VIRT_BITS - 3;
    localparam int SP_MOVED  = SP_LOW_W + 3;

    logic [VA_W-VIRT_BITS:0] upper;

    always_comb begin
        upper  = va[VA_W-1:VIRT_BITS-1];
        canon  = (&upper) | ~(|upper);
        sp_hit = canon & va[VA_W-1] & (va[SP_SEL_LO +: 2] == 2'b10);
        acv    = ~canon | (sp_hit & (mode != '0));
        sp_pa  = '0;
        sp_pa[SP_LOW_W-1:0] = va[SP_LOW_W-1:0];
        sp_pa[SP_MOVED]     = va[SP_LOW_W];
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]  pte,
    input  logic [MODE_W-1:0] mode,
    input  logic [PERM_W-1:0] need,
    output ptw_fault_e        fault,
    output logic [PERM_W-1:0] perm
);
    logic [PERM_W-1:0] grant;
    logic [PERM_W-1:0] kept;
    logic              rd_en;
    logic              wr_en;

    always_comb begin
        rd_en = pte[PTE_KRE + int'(mode)];
        wr_en = pte[PTE_KWE + int'(mode)];
        grant = '0;
        grant[PERM_R]   = rd_en;
        grant[PERM_X]   = rd_en;
        grant[PERM_W_B] = wr_en;
        kept  = grant & ~pte[PTE_FOE:PTE_FOR];
        perm  = '0;
        if (!pte[PTE_V]) begin
            fault = FLT_TNV;
        end else if ((grant & need) == '0) begin
            fault = FLT_ACV;
        end else if ((kept & need) == '0) begin
            if (need[PERM_X])        fault = FLT_FOE;
            else if (need[PERM_W_B]) fault = FLT_FOW;
            else                     fault = FLT_FOR;
        end else begin
            fault = FLT_NONE;
            perm  = kept;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 64,
    parameter int PG_BITS   = 13,
    parameter int IDX_W     = 10,
    parameter int VIRT_BITS = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_mode,
    input  logic [PA_W-1:0]   ptbr,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_pa,
    output logic [2:0]        done_perm,
    output logic [2:0]        done_fault
);
    localparam int ENT_SH = 3;
    localparam int FR_W   = PTE_W / 2;
    localparam int L1_LO  = PG_BITS + 2 * IDX_W;
    localparam int L2_LO  = PG_BITS + IDX_W;
    localparam int L3_LO  = PG_BITS;

    ptw_state_e         state, state_nx;
    logic [VA_W-1:0]    va_q;
    logic [MODE_W-1:0]  mode_q;
    logic [PERM_W-1:0]  need_q;
    logic [PA_W-1:0]    base_q;
    logic [PA_W-1:0]    pa_q;
    logic [PERM_W-1:0]  perm_q;
    ptw_fault_e         fault_q;

    logic               f_canon, f_sp, f_acv;
    logic [PA_W-1:0]    f_pa;
    ptw_fault_e         l3_fault;
    logic [PERM_W-1:0]  l3_perm;
    logic [PERM_W-1:0]  need_d;
    logic [IDX_W-1:0]   idx;
    logic [PA_W-1:0]    rsp_base;
    logic               rsp_bad;

    ptw_front #(.VA_W(VA_W), .VIRT_BITS(VIRT_BITS), .PA_W(PA_W)) u_front (
        .va(req_va), .mode(req_mode), .canon(f_canon), .sp_hit(f_sp),
        .acv(f_acv), .sp_pa(f_pa)
    );

    ptw_perm u_perm (
        .pte(mem_rsp_data), .mode(mode_q), .need(need_q),
        .fault(l3_fault), .perm(l3_perm)
    );

    always_comb begin
        unique case (req_acc)
            2'd1:    need_d = 3'b010;
            2'd2:    need_d = 3'b100;
            default: need_d = 3'b001;
        endcase
        rsp_base = PA_W'(mem_rsp_data[PTE_W-1:FR_W]) << PG_BITS;
        rsp_bad  = ~mem_rsp_data[PTE_V] | ~mem_rsp_data[PTE_KRE];
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = (f_acv | f_sp) ? ST_DONE : ST_L1;
            ST_L1:   if (mem_rsp_valid) state_nx = rsp_bad ? ST_DONE : ST_L2;
            ST_L2:   if (mem_rsp_valid) state_nx = rsp_bad ? ST_DONE : ST_L3;
            ST_L3:   if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Walk datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            mode_q  <= '0;
            need_q  <= 3'b001;
            base_q  <= '0;
            pa_q    <= '0;
            perm_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    mode_q  <= req_mode;
                    need_q  <= need_d;
                    base_q  <= ptbr;
                    pa_q    <= '0;
                    perm_q  <= '0;
                    fault_q <= FLT_NONE;
                    if (f_acv) begin
                        fault_q <= FLT_ACV;
                    end else if (f_sp) begin
                        pa_q   <= f_pa;
                        perm_q <= 3'b111;
                    end
                end
                ST_L1, ST_L2: if (mem_rsp_valid) begin
                    if (!mem_rsp_data[PTE_V])        fault_q <= FLT_TNV;
                    else if (!mem_rsp_data[PTE_KRE]) fault_q <= FLT_ACV;
                    else                             base_q  <= rsp_base;
                end
                ST_L3: if (mem_rsp_valid) begin
                    fault_q <= l3_fault;
                    perm_q  <= l3_perm;
                    if (l3_fault == FLT_NONE)
                        pa_q <= rsp_base | PA_W'(va_q[PG_BITS-1:0]);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_L1:   idx = va_q[L1_LO +: IDX_W];
            ST_L2:   idx = va_q[L2_LO +: IDX_W];
            default: idx = va_q[L3_LO +: IDX_W];
        endcase
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_L1) || (state == ST_L2) || (state == ST_L3);
        mem_req_addr  = base_q + (PA_W'(idx) << ENT_SH);
        done_valid    = (state == ST_DONE);
        done_pa       = pa_q;
        done_perm     = perm_q;
        done_fault    = fault_q;
    end

    // R2: a non-canonical address finishes in the next cycle with an access violation
    a_r2_noncanon_acv: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !f_canon) |=> (done_valid && done_fault == 3'd1));

    // R3: a superpage completes without opening a memory read
    a_r3_superpage_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && f_sp) |=> (done_valid && !mem_req_valid));

    // R9: a successful result grants the permission that was needed
    a_r9_grant_covers_need: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 3'd0) |-> ((done_perm & need_q) != 3'b000));

    // R10: an open read keeps its address until answered
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: responses only arrive while a read is open
    a_r10_rsp_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> mem_req_valid);

    // R11: the result is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R11: faults carry no address and no permissions
    a_r11_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault != 3'd0) |-> (done_pa == '0 && done_perm == 3'b000));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int LAT = 2;
    localparam logic [63:0] PTBR = 64'h0000_0000_0010_0000;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  acc;
        logic [1:0]  mode;
        logic [2:0]  flt;
        logic [2:0]  perm;
        logic [63:0] pa;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0002_0100_0123, 2'd0, 2'd0, 3'd0, 3'd7, 64'h0000_0000_0246_8123}, // R4 R5 R8
        '{64'h0000_0002_0100_0123, 2'd1, 2'd3, 3'd0, 3'd7, 64'h0000_0000_0246_8123}, // R8 mode 3
        '{64'h0000_0002_0100_2010, 2'd0, 2'd1, 3'd1, 3'd0, 64'h0},                   // R8 missing
        '{64'h0000_0002_0100_2010, 2'd2, 2'd0, 3'd0, 3'd7, 64'h0000_0000_000A_A010}, // R8 exec
        '{64'h0000_0002_0100_4000, 2'd0, 2'd0, 3'd2, 3'd0, 64'h0},                   // R6 L3
        '{64'h0000_0002_0100_7FFF, 2'd1, 2'd0, 3'd4, 3'd0, 64'h0},                   // R9 FOW
        '{64'h0000_0002_0100_7FFF, 2'd0, 2'd0, 3'd0, 3'd5, 64'h0000_0000_000E_FFFF}, // R9 masked
        '{64'h0000_0002_0100_8000, 2'd0, 2'd0, 3'd3, 3'd0, 64'h0},                   // R9 FOR
        '{64'h0000_0002_0100_8000, 2'd2, 2'd0, 3'd0, 3'd6, 64'h0000_0000_0011_0000}, // R9 masked
        '{64'h0000_0002_0100_A000, 2'd2, 2'd0, 3'd5, 3'd0, 64'h0},                   // R9 FOE
        '{64'h0000_0006_0000_0000, 2'd0, 2'd0, 3'd2, 3'd0, 64'h0},                   // R6 L1
        '{64'h0000_0008_0000_0000, 2'd0, 2'd0, 3'd1, 3'd0, 64'h0},                   // R7 L1
        '{64'h0000_0002_0280_0000, 2'd0, 2'd0, 3'd1, 3'd0, 64'h0},                   // R7 L2
        '{64'h0000_0002_0300_0000, 2'd0, 2'd0, 3'd2, 3'd0, 64'h0},                   // R6 L2
        '{64'h0000_0400_0000_0000, 2'd0, 2'd0, 3'd1, 3'd0, 64'h0},                   // R2
        '{64'hFFFF_FD12_3456_789A, 2'd1, 2'd0, 3'd0, 3'd7, 64'h0000_0812_3456_789A}, // R3
        '{64'hFFFF_FD12_3456_789A, 2'd0, 2'd1, 3'd1, 3'd0, 64'h0},                   // R3 user
        '{64'hFFFF_FE00_0000_0000, 2'd0, 2'd0, 3'd2, 3'd0, 64'h0}                    // R3 not sp
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_mode = '0;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [63:0] done_pa;
    logic [2:0]  done_perm;
    logic [2:0]  done_fault;

    int checks = 0;
    int fails = 0;
    int reads = 0;
    int cycles = 0;
    logic busy_ready;

    always #2 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_acc(req_acc), .req_mode(req_mode), .ptbr(PTBR),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_pa(done_pa), .done_perm(done_perm),
        .done_fault(done_fault)
    );

    function automatic logic [63:0] mem_at(input logic [63:0] a);
        case (a)
            64'h10_0008: return 64'h0000_0100_0000_0101;
            64'h10_0020: return 64'h0000_0100_0000_0001;
            64'h20_0010: return 64'h0000_0180_0000_0101;
            64'h20_0028: return 64'h0000_0180_0000_0001;
            64'h30_0000: return 64'h0000_1234_0000_FF01;
            64'h30_0008: return 64'h0000_0055_0000_1101;
            64'h30_0010: return 64'h0000_0066_0000_FF00;
            64'h30_0018: return 64'h0000_0077_0000_FF05;
            64'h30_0020: return 64'h0000_0088_0000_FF03;
            64'h30_0028: return 64'h0000_0099_0000_FF09;
            default:     return 64'h0;
        endcase
    endfunction

    // Memory model: one pending read, answered after LAT cycles
    initial begin
        logic pending;
        int   cnt;
        pending = 0;
        cnt = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (!rst_n) begin
                pending = 0;
            end else if (pending) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = mem_at(mem_req_addr);
                    pending = 0;
                end else begin
                    cnt--;
                end
            end else if (mem_req_valid) begin
                pending = 1;
                cnt = LAT;
                reads++;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Issue one request and wait for its result (sampled at negedge)
    task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode);
        int t;
        @(negedge clk);
        req_valid = 1; req_va = va; req_acc = acc; req_mode = mode;
        @(negedge clk);
        req_valid = 0;
        busy_ready = req_ready;
        t = 0;
        while (!done_valid && t < 1000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 1000) begin
            checks++; fails++;
            $display("FAIL R11 result timeout actual=0 expected=1");
        end
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "req_ready", 64'(req_ready), 64'd1);
        check("R1", "done_valid", 64'(done_valid), 64'd0);
        check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].va, VECS[i].acc, VECS[i].mode);
            check("R6-R9 vector fault", $sformatf("v%0d fault", i), 64'(done_fault), 64'(VECS[i].flt));
            check("R5 R9 R11 vector perm", $sformatf("v%0d perm", i), 64'(done_perm), 64'(VECS[i].perm));
            check("R3 R5 R11 vector pa", $sformatf("v%0d pa", i), done_pa, VECS[i].pa);
            @(negedge clk);
            check("R11", "pulse ends", 64'(done_valid), 64'd0);
        end

        // R10: ready low during a walk; R4: full walk makes three reads
        r0 = reads;
        run(VECS[0].va, 2'd0, 2'd0);
        check("R10", "ready while walking", 64'(busy_ready), 64'd0);
        check("R4", "reads for full walk", 64'(reads - r0), 64'd3);
        @(negedge clk);

        // R3: superpage makes no memory read; R2 likewise
        r0 = reads;
        run(VECS[15].va, 2'd2, 2'd0);
        check("R3", "superpage reads", 64'(reads - r0), 64'd0);
        check("R3", "superpage pa", done_pa, VECS[15].pa);
        @(negedge clk);
        r0 = reads;
        run(VECS[14].va, 2'd0, 2'd0);
        check("R2", "noncanonical reads", 64'(reads - r0), 64'd0);
        @(negedge clk);

        // R7: KRE missing at L1 stops after one read
        r0 = reads;
        run(VECS[11].va, 2'd0, 2'd0);
        check("R7", "reads before L1 reject", 64'(reads - r0), 64'd1);
        @(negedge clk);

        // R1: reset mid-walk returns to idle
        @(negedge clk);
        req_valid = 1; req_va = VECS[0].va; req_acc = 0; req_mode = 0;
        @(negedge clk);
        req_valid = 0;
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "ready after reset", 64'(req_ready), 64'd1);
        check("R1", "mem idle after reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule